// File: doc/BRIEF.md
# Paged Receive Ring Write Manager

This block is the writing side of a receive packet memory. The memory is cut into 256-byte pages, and a span of those pages, from a base page to a high page, forms a ring. Bytes of each incoming packet arrive as a stream with start, end and drop markers. The block turns them into byte writes to the packet memory and advances its write page pointer page by page, always to the next page in ring order. Before each page change it checks that the next page is not the page the host is still reading.

Each packet begins four bytes into its first page. Those four bytes hold a status descriptor that is written in one wide write when the packet closes. A packet rejected by the address filter leaves no trace, because the write pointer returns to the page where the packet began.

When the ring fills in the middle of a packet, the packet is closed with overflow and buffer-full flags and its pages are given back. The block then either resumes with the next packet (automatic recovery) or stops accepting packets and counts each lost one. It stays stopped until software removes the start enable.

Top module: `rx_page_ring_wr`

## Requirements
- R1: After reset, `wr_page` is 0x00, `missed_cnt` is 0, `irq` is low, and neither `mem_we` nor `desc_we` is asserted.
- R2: `load_page` loads `load_value` into `wr_page` only while `start_en` is low and no packet is in progress. While `start_en` is low, no incoming packet causes any write.
- R3: The first byte of an accepted packet is written one cycle after it arrives, at byte address {wr_page, 0x04}. Each following byte goes to the next offset. Byte address = {page[15:8], offset[7:0]}.
- R4: A byte that arrives after offset 0xFF has been used goes to offset 0x00 of the next ring page. That page is `base_page` when the current page equals `high_page`, and the current page plus one otherwise. `wr_page` follows it.
- R5: If, at such a page change, the next ring page equals `read_page`, the packet is aborted. A descriptor is written at {start page, 0x00} with status 0x09 (bit 3 overflow, bit 0 buffer full), the start page in bits [15:8] and the count of stored bytes in bits [31:16]. `wr_page` returns to the start page, and the rest of the packet is not written.
- R6: When a packet ends normally, a descriptor is written at {start page, 0x00}. Its status is 0x02 in bits [7:0], the ring page after the last page used is in bits [15:8], and the payload byte count is in bits [31:16]. `wr_page` then moves to that following page.
- R7: A drop marker during a packet ends it with no descriptor and no further writes, and `wr_page` returns to the start page.
- R8: With `auto_recover` high, the packet after an aborted one is accepted and stored normally.
- R9: With `auto_recover` low, an abort stops reception. While stopped, no write is made, and each arriving packet start increments `missed_cnt`. Dropping `start_en` ends the stop.
- R10: `missed_cnt` saturates at 0xFFFF and is cleared by `mpc_clear`, which takes priority over an increment.
- R11: A ring-full abort sets a sticky buffer-full flag that `bf_clear` clears. `irq` is high exactly when that flag and `bf_mask` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_en | input | 1 | Reception enable from software |
| auto_recover | input | 1 | Discard and resume after a ring-full abort |
| load_page | input | 1 | Load the write page pointer |
| load_value | input | 8 | Value for the write page pointer |
| base_page | input | 8 | First page of the ring |
| high_page | input | 8 | Last page of the ring |
| read_page | input | 8 | Host read page pointer |
| rx_valid | input | 1 | Byte valid on `rx_data` |
| rx_sof | input | 1 | Byte is the first of a packet |
| rx_eof | input | 1 | Byte is the last of a packet |
| rx_drop | input | 1 | Reject the packet in progress |
| rx_data | input | 8 | Packet byte |
| mpc_clear | input | 1 | Clear the missed-packet counter |
| bf_clear | input | 1 | Clear the buffer-full flag |
| bf_mask | input | 1 | Interrupt mask for buffer full |
| mem_we | output | 1 | Packet byte write strobe |
| mem_addr | output | 16 | Packet byte write address |
| mem_data | output | 8 | Packet byte write data |
| desc_we | output | 1 | Descriptor write strobe |
| desc_addr | output | 16 | Descriptor byte address (page base) |
| desc_data | output | 32 | Descriptor word: count, next page, status |
| wr_page | output | 8 | Write page pointer |
| missed_cnt | output | 16 | Missed-packet counter |
| irq | output | 1 | Buffer-full interrupt |

## Verification
The assertions check several rules on every cycle. After an abort or a drop, the write pointer must return to the packet's start page. A plain page change must follow ring order, including the wrap from the high page to the base page. The missed counter must never fall unless it is cleared, and it must step by one on each packet start while stopped. No byte may be written while stopped, the interrupt may only rise with its mask set, and the close, abort and drop events must be mutually exclusive. Only the bench's scenarios can show the end-to-end results: descriptor contents and addresses, the exact byte address across a page change and across the ring wrap, recovery with the next packet, saturation after tens of thousands of lost packets, and the leave-stop sequence.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RECV = 2'd1, ST_HALT = 2'd2} rbr_state_e;

  localparam int STAT_BUF_FULL = 0;
  localparam int STAT_GOOD     = 1;
  localparam int STAT_OVERFLOW = 3;

  // status byte for a descriptor: good close or ring-full abort
  function automatic logic [7:0] status_byte(input logic good);
    logic [7:0] s;
    s = '0;
    if (good) begin
      s[STAT_GOOD] = 1'b1;
    end else begin
      s[STAT_OVERFLOW] = 1'b1;
      s[STAT_BUF_FULL] = 1'b1;
    end
    return s;
  endfunction
endpackage

// File: rtl/rbr_link.sv
module rbr_link #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] cur_page,
  input  logic [PAGE_W-1:0] base_page,
  input  logic [PAGE_W-1:0] high_page,
  output logic [PAGE_W-1:0] nxt_page
);
  // next page in ring order, wrapping from the high page to the base page
  function automatic logic [PAGE_W-1:0] ring_step(input logic [PAGE_W-1:0] p,
                                                  input logic [PAGE_W-1:0] lo,
                                                  input logic [PAGE_W-1:0] hi);
    return (p == hi) ? lo : p + 1'b1;
  endfunction

  assign nxt_page = ring_step(cur_page, base_page, high_page);
endmodule

// File: rtl/rbr_miss_ctr.sv
module rbr_miss_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != {CNT_W{1'b1}})) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_page_ring_wr.sv
module rx_page_ring_wr
  import rbr_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 8,
  parameter int BCNT_W     = 16,
  parameter int MISS_W     = 16,
  parameter int DESC_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_en,
  input  logic                          auto_recover,
  input  logic                          load_page,
  input  logic [PAGE_W-1:0]             load_value,
  input  logic [PAGE_W-1:0]             base_page,
  input  logic [PAGE_W-1:0]             high_page,
  input  logic [PAGE_W-1:0]             read_page,
  input  logic                          rx_valid,
  input  logic                          rx_sof,
  input  logic                          rx_eof,
  input  logic                          rx_drop,
  input  logic [7:0]                    rx_data,
  input  logic                          mpc_clear,
  input  logic                          bf_clear,
  input  logic                          bf_mask,
  output logic                          mem_we,
  output logic [PAGE_W+OFF_W-1:0]       mem_addr,
  output logic [7:0]                    mem_data,
  output logic                          desc_we,
  output logic [PAGE_W+OFF_W-1:0]       desc_addr,
  output logic [8+PAGE_W+BCNT_W-1:0]    desc_data,
  output logic [PAGE_W-1:0]             wr_page,
  output logic [MISS_W-1:0]             missed_cnt,
  output logic                          irq
);
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int DESC_W = 8 + PAGE_W + BCNT_W;
  localparam logic [OFF_W-1:0] FIRST_OFF = OFF_W'(DESC_BYTES);

  rbr_state_e          state_q;
  logic [PAGE_W-1:0]   wr_page_q, start_q;
  logic [OFF_W-1:0]    off_q;
  logic [BCNT_W-1:0]   cnt_q;
  logic                bf_q;

  // named internal events
  logic ev_sof_take, in_recv_byte, need_link, ring_full;
  logic ev_link, ev_full, ev_reject, ev_write, ev_good_end, ev_missed;

  logic [PAGE_W-1:0]   nxt_cur, nxt_end, wr_pg, desc_pg;
  logic [OFF_W-1:0]    wr_off;
  logic [BCNT_W-1:0]   cnt_new;

  rbr_link #(.PAGE_W(PAGE_W)) u_link_cur (
    .cur_page(wr_page_q), .base_page(base_page), .high_page(high_page), .nxt_page(nxt_cur)
  );

  rbr_link #(.PAGE_W(PAGE_W)) u_link_end (
    .cur_page(wr_pg), .base_page(base_page), .high_page(high_page), .nxt_page(nxt_end)
  );

  rbr_miss_ctr #(.CNT_W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .clr(mpc_clear), .inc(ev_missed), .cnt(missed_cnt)
  );

  assign ev_sof_take  = (state_q == ST_IDLE) && start_en && rx_valid && rx_sof;
  assign in_recv_byte = (state_q == ST_RECV) && rx_valid && !rx_drop;
  assign ev_reject    = (state_q == ST_RECV) && rx_drop;
  assign need_link    = in_recv_byte && (off_q == '0);
  assign ring_full    = (nxt_cur == read_page);
  assign ev_full      = need_link && ring_full;
  assign ev_link      = need_link && !ring_full;
  assign ev_write     = ev_sof_take || (in_recv_byte && !ev_full);
  assign ev_good_end  = (ev_sof_take && rx_eof) || (in_recv_byte && rx_eof && !ev_full);
  assign ev_missed    = (state_q == ST_HALT) && rx_valid && rx_sof;

  always_comb begin
    if (ev_sof_take) begin
      wr_pg  = wr_page_q;
      wr_off = FIRST_OFF;
    end else if (ev_link) begin
      wr_pg  = nxt_cur;
      wr_off = '0;
    end else begin
      wr_pg  = wr_page_q;
      wr_off = off_q;
    end
  end

  assign cnt_new = ev_sof_take ? BCNT_W'(1) : cnt_q + 1'b1;
  assign desc_pg = ev_sof_take ? wr_page_q : start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_page_q <= '0;
      start_q   <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      bf_q      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      desc_we   <= 1'b0;
      desc_addr <= '0;
      desc_data <= '0;
    end else begin
      mem_we <= ev_write;
      if (ev_write) begin
        mem_addr <= ADDR_W'({wr_pg, wr_off});
        mem_data <= rx_data;
        off_q    <= wr_off + 1'b1;
        cnt_q    <= cnt_new;
      end
      desc_we <= ev_good_end || ev_full;
      if (ev_good_end || ev_full) begin
        desc_addr <= {desc_pg, {OFF_W{1'b0}}};
        desc_data <= ev_full ? DESC_W'({cnt_q, start_q, status_byte(1'b0)})
                             : DESC_W'({cnt_new, nxt_end, status_byte(1'b1)});
      end
      if (ev_sof_take) start_q <= wr_page_q;

      if (load_page && !start_en && (state_q != ST_RECV)) wr_page_q <= load_value;
      else if (ev_good_end)                               wr_page_q <= nxt_end;
      else if (ev_full || ev_reject)                      wr_page_q <= start_q;
      else if (ev_link)                                   wr_page_q <= nxt_cur;

      case (state_q)
        ST_IDLE: if (ev_sof_take && !rx_eof) state_q <= ST_RECV;
        ST_RECV: begin
          if (ev_reject || ev_good_end) state_q <= ST_IDLE;
          else if (ev_full)             state_q <= auto_recover ? ST_IDLE : ST_HALT;
        end
        ST_HALT: if (!start_en) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase

      if (ev_full)       bf_q <= 1'b1;
      else if (bf_clear) bf_q <= 1'b0;
    end
  end

  assign wr_page = wr_page_q;
  assign irq     = bf_q && bf_mask;
endmodule

// File: rtl/rx_page_ring_wr_chk.sv
module rx_page_ring_wr_chk
  import rbr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input rbr_state_e        state_q,
  input logic              ev_full,
  input logic              ev_reject,
  input logic              ev_link,
  input logic              ev_good_end,
  input logic              ev_missed,
  input logic [PAGE_W-1:0] wr_page,
  input logic [PAGE_W-1:0] start_q,
  input logic [PAGE_W-1:0] base_page,
  input logic [PAGE_W-1:0] high_page,
  input logic              mem_we,
  input logic              desc_we,
  input logic              irq,
  input logic              bf_mask,
  input logic              mpc_clear,
  input logic [MISS_W-1:0] missed_cnt
);
  // R5
  full_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> (wr_page == $past(start_q)) && desc_we);

  // R7
  reject_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (wr_page == $past(start_q)) && !desc_we);

  // R4
  link_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_link && !ev_good_end) |=>
      (wr_page == (($past(wr_page) == $past(high_page)) ? $past(base_page)
                                                         : PAGE_W'($past(wr_page) + 1'b1))));

  // R9
  halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |=> !mem_we);

  // R9
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_missed && !mpc_clear && (missed_cnt != {MISS_W{1'b1}})) |=>
      (missed_cnt == MISS_W'($past(missed_cnt) + 1'b1)));

  // R10
  miss_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mpc_clear |=> (missed_cnt >= $past(missed_cnt)));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bf_mask);

  // R5
  close_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_full, ev_good_end, ev_reject}));
endmodule

bind rx_page_ring_wr rx_page_ring_wr_chk #(.PAGE_W(PAGE_W), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .ev_full(ev_full), .ev_reject(ev_reject),
  .ev_link(ev_link), .ev_good_end(ev_good_end), .ev_missed(ev_missed), .wr_page(wr_page),
  .start_q(start_q), .base_page(base_page), .high_page(high_page), .mem_we(mem_we),
  .desc_we(desc_we), .irq(irq), .bf_mask(bf_mask), .mpc_clear(mpc_clear),
  .missed_cnt(missed_cnt)
);

// File: tb/rx_page_ring_wr_bench.sv
module rx_page_ring_wr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_en = 0, auto_recover = 0, load_page = 0;
  logic [7:0] load_value = 0, base_page = 0, high_page = 0, read_page = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_drop = 0;
  logic [7:0] rx_data = 0;
  logic mpc_clear = 0, bf_clear = 0, bf_mask = 0;
  logic mem_we, desc_we, irq;
  logic [15:0] mem_addr, desc_addr, missed_cnt;
  logic [7:0] mem_data, wr_page;
  logic [31:0] desc_data;

  always #2 clk = ~clk;

  rx_page_ring_wr u_rx_page_ring_wr (
    .clk(clk), .rst_n(rst_n), .start_en(start_en), .auto_recover(auto_recover),
    .load_page(load_page), .load_value(load_value), .base_page(base_page),
    .high_page(high_page), .read_page(read_page), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_drop(rx_drop), .rx_data(rx_data), .mpc_clear(mpc_clear),
    .bf_clear(bf_clear), .bf_mask(bf_mask), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .desc_we(desc_we), .desc_addr(desc_addr), .desc_data(desc_data),
    .wr_page(wr_page), .missed_cnt(missed_cnt), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode, m_pg, m_first, m_pos, m_n, m_missed, m_bf;
  int e_we, e_addr, e_data, e_dwe, e_daddr, e_ddata;

  function automatic int ring_after(input int p);
    if (p == int'(high_page)) return int'(base_page);
    return (p + 1) % 256;
  endfunction

  task automatic m_put();
    e_we = 1; e_addr = m_pg * 256 + m_pos; e_data = int'(rx_data);
    m_pos++; m_n++;
  endtask

  task automatic m_close_good();
    int nx;
    nx = ring_after(m_pg);
    e_dwe = 1; e_daddr = m_first * 256;
    e_ddata = (m_n << 16) | (nx << 8) | 'h02;
    m_pg = nx; m_mode = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pg = 0; m_first = 0; m_pos = 0; m_n = 0; m_missed = 0; m_bf = 0;
      e_we = 0; e_dwe = 0; e_addr = 0; e_data = 0; e_daddr = 0; e_ddata = 0;
    end else begin
      e_we = 0; e_dwe = 0;
      if (m_mode == 2 && rx_valid && rx_sof && m_missed < 65535) m_missed++;
      if (mpc_clear) m_missed = 0;
      if (bf_clear) m_bf = 0;
      if (load_page && !start_en && m_mode != 1) m_pg = int'(load_value);
      if (m_mode == 0) begin
        if (start_en && rx_valid && rx_sof) begin
          m_first = m_pg; m_pos = 4; m_n = 0;
          m_put();
          if (rx_eof) m_close_good(); else m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (rx_drop) begin
          m_pg = m_first; m_mode = 0;
        end else if (rx_valid) begin
          bit aborted;
          aborted = 0;
          if (m_pos == 256) begin
            if (ring_after(m_pg) == int'(read_page)) begin
              aborted = 1;
              e_dwe = 1; e_daddr = m_first * 256;
              e_ddata = (m_n << 16) | (m_first << 8) | 'h09;
              m_bf = 1; m_pg = m_first;
              m_mode = auto_recover ? 0 : 2;
            end else begin
              m_pg = ring_after(m_pg); m_pos = 0;
            end
          end
          if (!aborted) begin
            m_put();
            if (rx_eof) m_close_good();
          end
        end
      end else begin
        if (!start_en) m_mode = 0;
      end
    end
  end

  // per-cycle comparison and scenario capture, away from the edge
  int wcount = 0, dcount = 0, addr_first = 0, addr_253 = 0;
  int d_addr = 0, d_stat = 0, d_next = 0, d_cnt = 0;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R3 mem_we", int'(mem_we), e_we);
      if (e_we != 0) begin
        chk("R3 mem_addr", int'(mem_addr), e_addr);
        chk("R3 mem_data", int'(mem_data), e_data);
      end
      chk("R6 desc_we", int'(desc_we), e_dwe);
      if (e_dwe != 0) begin
        chk("R6 desc_addr", int'(desc_addr), e_daddr);
        chk("R6 desc_data", int'(desc_data), e_ddata);
      end
      chk("R4 wr_page", int'(wr_page), m_pg);
      chk("R10 missed_cnt", int'(missed_cnt), m_missed);
      chk("R11 irq", int'(irq), m_bf & int'(bf_mask));
      if (mem_we) begin
        wcount++;
        if (wcount == 1) addr_first = int'(mem_addr);
        if (wcount == 253) addr_253 = int'(mem_addr);
      end
      if (desc_we) begin
        dcount++;
        d_addr = int'(desc_addr); d_stat = int'(desc_data[7:0]);
        d_next = int'(desc_data[15:8]); d_cnt = int'(desc_data[31:16]);
      end
    end
  end

  task automatic idle_inputs();
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_drop = 0;
  endtask

  task automatic send(input int n, input int drop_at);
    wcount = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = (i != drop_at);
      rx_drop  = (i == drop_at);
      rx_sof   = (i == 0);
      rx_eof   = (i == n - 1);
      rx_data  = 8'(i + 7);
    end
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_desc(input string req, input int a, input int s, input int nx, input int c);
    chk({req, " desc addr"}, d_addr, a);
    chk({req, " desc status"}, d_stat, s);
    chk({req, " desc next"}, d_next, nx);
    chk({req, " desc count"}, d_cnt, c);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_page", int'(wr_page), 0);
    chk("R1 missed", int'(missed_cnt), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 writes", int'(mem_we) + int'(desc_we), 0);

    base_page = 8'd2; high_page = 8'd5; read_page = 8'd0;
    auto_recover = 1; bf_mask = 1;
    // R2 pointer load while stopped
    load_page = 1; load_value = 8'd2;
    @(negedge clk); load_page = 0;
    @(negedge clk);
    chk("R2 load", int'(wr_page), 2);
    d0 = dcount;
    send(5, -1);
    chk("R2 no write while disabled", wcount, 0);
    chk("R2 no descriptor while disabled", dcount, d0);

    start_en = 1;
    send(10, -1);
    chk("R3 first byte address", addr_first, 'h0204);
    check_desc("R6", 'h0200, 'h02, 3, 10);
    chk("R6 wr_page", int'(wr_page), 3);

    send(300, -1);
    chk("R4 page link address", addr_253, 'h0400);
    check_desc("R4", 'h0300, 'h02, 5, 300);

    send(300, -1);
    chk("R4 wrap address", addr_253, 'h0200);
    check_desc("R4 wrap", 'h0500, 'h02, 3, 300);
    chk("R4 wr_page after wrap", int'(wr_page), 3);

    d0 = dcount;
    send(20, 10);
    chk("R7 writes before drop", wcount, 10);
    chk("R7 no descriptor", dcount, d0);
    chk("R7 wr_page", int'(wr_page), 3);

    read_page = 8'd4;
    send(300, -1);
    chk("R5 bytes stored", wcount, 252);
    check_desc("R5", 'h0300, 'h09, 3, 252);
    chk("R5 wr_page", int'(wr_page), 3);
    chk("R11 irq set", int'(irq), 1);
    bf_mask = 0;
    @(negedge clk);
    chk("R11 irq masked", int'(irq), 0);
    bf_mask = 1; bf_clear = 1;
    @(negedge clk); bf_clear = 0;
    @(negedge clk);
    chk("R11 irq cleared", int'(irq), 0);

    send(10, -1);
    check_desc("R8 recovered", 'h0300, 'h02, 4, 10);
    chk("R8 wr_page", int'(wr_page), 4);

    auto_recover = 0; read_page = 8'd5;
    send(300, -1);
    check_desc("R9 abort", 'h0400, 'h09, 4, 252);
    send(5, -1); send(5, -1);
    send(5, -1);
    chk("R9 no write while stopped", wcount, 0);
    chk("R9 missed count", int'(missed_cnt), 3);
    mpc_clear = 1;
    @(negedge clk); mpc_clear = 0;
    @(negedge clk);
    chk("R10 clear", int'(missed_cnt), 0);

    for (int k = 0; k < 65537; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = 1; rx_eof = 1;
    end
    @(negedge clk); idle_inputs();
    @(negedge clk);
    chk("R10 saturate", int'(missed_cnt), 'hFFFF);

    start_en = 0;
    @(negedge clk);
    read_page = 8'd0; start_en = 1;
    @(negedge clk);
    send(5, -1);
    check_desc("R9 leave stop", 'h0400, 'h02, 5, 5);
    chk("R9 wr_page", int'(wr_page), 5);

    finish_run();
  end
endmodule